// File: doc/BRIEF.md
# Snoop write-back start scheduler

When a snoop finds a modified line, this block launches the bus write-back of that line. The responder raises a request and supplies the snoop address. The block then works out when the write-back may start. Normally the write-back waits until every bus cycle already in flight has returned its final data-ready. If the responder also asks for an immediate flush, the write-back may overlap cycles that are still in flight.

Once the start is allowed, a small timer places the cycle-start strobe a fixed number of clocks later. That number is set by a parameter and lies between one and four. While the control pins are floated for a bus hold or a back-off, the strobe is held back.

After the strobe, the block steps through a four-beat burst. The beat addresses are always in ascending order, and the low bits of the snoop address play no part in them. The block drives the address bus only while address hold is released. The strobe itself may still go out under address hold, with the address left undriven. A done pulse on the final beat tells the responder it may release its hit-modified indication.

Top module: `snoop_wb_sched`

## Requirements
- R1: Out of reset the block is idle: `wb_start`, `wb_busy`, `addr_oe` and `wb_done` are all low.
- R2: With no bus cycles in flight, `wb_start` goes high for exactly one clock, START_DLY clocks after the clock in which `hitm_req` is sampled high (START_DLY defaults to 2, legal range 1 to 4).
- R3: With cycles in flight and no flush requested, `wb_start` goes high START_DLY clocks after the clock in which `cyc_retire` retires the last of them, and never earlier.
- R4: If `flush_now` is high with `hitm_req`, the start is timed from the request clock even while cycles are in flight.
- R5: The in-flight count rises on `cyc_issue` and falls on `cyc_retire`, saturating at three. After four issues, three retires therefore count as fully drained.
- R6: `wb_addr` equals the snoop line address with byte offsets 0x00, 0x08, 0x10 and 0x18 for beats 0 to 3, ignoring `snoop_addr[4:0]`. Beat 0 is presented from the start strobe onward.
- R7: The burst advances one beat only in a clock with `beat_rdy` high. Without `beat_rdy` the beat stays where it is.
- R8: `wb_done` is high in the clock in which `beat_rdy` accepts beat 3. `wb_busy` is low in the next clock.
- R9: `addr_oe` is high only during the start strobe or the burst, and only while `addr_hold` is low. `wb_start` still issues while `addr_hold` is high.
- R10: While `ctl_float` is high, `wb_start` stays low. A start whose delay has run out issues in the first clock in which `ctl_float` is low.
- R11: A `hitm_req` that arrives while a write-back is busy is ignored. The burst address does not change, and no second start follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hitm_req | input | 1 | Snoop hit a modified line; request a write-back |
| snoop_addr | input | ADDR_W | Snoop address; bits [4:0] are ignored |
| flush_now | input | 1 | Immediate flush: do not wait for cycles in flight |
| cyc_issue | input | 1 | A new ordinary bus cycle was started |
| cyc_retire | input | 1 | Final data-ready of an in-flight ordinary cycle |
| beat_rdy | input | 1 | Data-ready for the current write-back beat |
| addr_hold | input | 1 | Address hold in effect; address bus must float |
| ctl_float | input | 1 | Hold acknowledge or back-off; control pins floated |
| wb_start | output | 1 | Cycle-start strobe of the write-back |
| wb_busy | output | 1 | A write-back is pending or in progress |
| wb_addr | output | ADDR_W | Address of the current write-back beat |
| addr_oe | output | 1 | Address bus output enable |
| wb_done | output | 1 | Pulse on the final beat of the write-back |

## Verification
The bench targets the moment the start strobe appears in each case: an idle bus, a bus with several cycles still in flight, the flush override, and a saturated in-flight count. A scheduler that counted from the wrong event would strobe a cycle early or late. One that ignored saturation would wait forever for a fourth retire. Burst pacing with gaps between data-ready pulses and a request whose low address bits are set would expose a beat that runs ahead or an address that keeps the low bits. Float and address-hold windows placed across the strobe would expose a strobe issued onto floated pins, or an address driven under hold. A second request landing mid-burst would expose a design that lets a new snoop corrupt the line address.

// File: rtl/snoop_wb_pkg.sv
package snoop_wb_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_WAIT  = 2'd1,
    PH_DELAY = 2'd2,
    PH_BURST = 2'd3
  } wb_phase_e;

endpackage

// File: rtl/snoop_wb_outst.sv
// Tracks ordinary bus cycles in flight; saturating count.
module snoop_wb_outst #(
  parameter int MAX_OUT = 3,
  localparam int CW     = $clog2(MAX_OUT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic          retire,
  output logic [CW-1:0] count,
  output logic          drained
);

  logic [CW-1:0] count_q, count_d;

  always_comb begin
    count_d = count_q;
    if (issue && !retire) begin
      if (count_q != CW'(MAX_OUT)) count_d = count_q + CW'(1);
    end else if (retire && !issue) begin
      if (count_q != '0) count_d = count_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  assign count   = count_q;
  assign drained = (count_q == '0) ||
                   ((count_q == CW'(1)) && retire && !issue);

  AST_OUTST_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(MAX_OUT)); // R5
  AST_OUTST_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == CW'(MAX_OUT)) && issue && !retire |=> count_q == CW'(MAX_OUT)); // R5

endmodule

// File: rtl/snoop_wb_dly.sv
// Start-delay timer: counts from 1 up to START_DLY once armed.
module snoop_wb_dly #(
  parameter int START_DLY = 2,
  localparam int CW       = $clog2(START_DLY + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic run,
  output logic expired
);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (arm)                                  cnt_d = CW'(1);
    else if (run && cnt_q != CW'(START_DLY))  cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = run && (cnt_q == CW'(START_DLY));

  AST_DLY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q >= CW'(1)) && (cnt_q <= CW'(START_DLY))); // R2

endmodule

// File: rtl/snoop_wb_beats.sv
// Burst beat sequencer: fixed ascending beat order, low address bits from the beat index.
module snoop_wb_beats #(
  parameter int ADDR_W     = 32,
  parameter int BEATS      = 4,
  parameter int BEAT_BYTES = 8,
  localparam int BW        = $clog2(BEATS),
  localparam int BBW       = $clog2(BEAT_BYTES),
  localparam int OFF       = BW + BBW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              advance,
  input  logic [ADDR_W-1:OFF] line,
  output logic [ADDR_W-1:0] addr,
  output logic              last
);

  logic [BW-1:0] beat_q, beat_d;

  always_comb begin
    beat_d = beat_q;
    if (clear)        beat_d = '0;
    else if (advance) beat_d = beat_q + BW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) beat_q <= '0;
    else        beat_q <= beat_d;
  end

  assign addr = {line, beat_q, {BBW{1'b0}}};
  assign last = (beat_q == BW'(BEATS - 1));

  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    advance && !clear && !last |=> addr[OFF-1:0] == $past(addr[OFF-1:0]) + OFF'(BEAT_BYTES)); // R6
  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !advance && !clear |=> $stable(addr[OFF-1:0])); // R7

endmodule

// File: rtl/snoop_wb_sched.sv
module snoop_wb_sched
  import snoop_wb_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int START_DLY  = 2,
  parameter int MAX_OUT    = 3,
  parameter int BEATS      = 4,
  parameter int BEAT_BYTES = 8,
  localparam int OFF       = $clog2(BEATS) + $clog2(BEAT_BYTES),
  localparam int OCW       = $clog2(MAX_OUT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hitm_req,
  input  logic [ADDR_W-1:0] snoop_addr,
  input  logic              flush_now,
  input  logic              cyc_issue,
  input  logic              cyc_retire,
  input  logic              beat_rdy,
  input  logic              addr_hold,
  input  logic              ctl_float,
  output logic              wb_start,
  output logic              wb_busy,
  output logic [ADDR_W-1:0] wb_addr,
  output logic              addr_oe,
  output logic              wb_done
);

  wb_phase_e             phase_q, phase_d;
  logic [ADDR_W-1:OFF]   line_q;
  logic                  flush_q;
  logic                  accept, may_go, arm, expired, drained, last_beat;
  logic [OCW-1:0]        out_cnt;
  logic                  unused_low;

  assign unused_low = ^snoop_addr[OFF-1:0];

  snoop_wb_outst #(.MAX_OUT(MAX_OUT)) u_outst (
    .clk     (clk),
    .rst_n   (rst_n),
    .issue   (cyc_issue),
    .retire  (cyc_retire),
    .count   (out_cnt),
    .drained (drained)
  );

  snoop_wb_dly #(.START_DLY(START_DLY)) u_dly (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (arm),
    .run     (phase_q == PH_DELAY),
    .expired (expired)
  );

  snoop_wb_beats #(
    .ADDR_W     (ADDR_W),
    .BEATS      (BEATS),
    .BEAT_BYTES (BEAT_BYTES)
  ) u_beats (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (phase_q != PH_BURST),
    .advance ((phase_q == PH_BURST) && beat_rdy),
    .line    (line_q),
    .addr    (wb_addr),
    .last    (last_beat)
  );

  assign accept = (phase_q == PH_IDLE) && hitm_req;
  assign may_go = drained || ((phase_q == PH_IDLE) ? flush_now : flush_q);
  assign arm    = (accept && may_go) || ((phase_q == PH_WAIT) && may_go);

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:  if (hitm_req) phase_d = may_go ? PH_DELAY : PH_WAIT;
      PH_WAIT:  if (may_go)   phase_d = PH_DELAY;
      PH_DELAY: if (expired && !ctl_float) phase_d = PH_BURST;
      PH_BURST: if (beat_rdy && last_beat) phase_d = PH_IDLE;
      default:  phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      line_q  <= '0;
      flush_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      if (accept) begin
        line_q  <= snoop_addr[ADDR_W-1:OFF];
        flush_q <= flush_now;
      end
    end
  end

  assign wb_start = (phase_q == PH_DELAY) && expired && !ctl_float;
  assign wb_busy  = (phase_q != PH_IDLE);
  assign wb_done  = (phase_q == PH_BURST) && beat_rdy && last_beat;
  assign addr_oe  = (wb_start || (phase_q == PH_BURST)) && !addr_hold;

  AST_NO_PIPELINE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_start && !flush_q |-> out_cnt == '0); // R3
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_start |=> !wb_start); // R2
  AST_START_BEAT0: assert property (@(posedge clk) disable iff (!rst_n)
    wb_start |-> wb_addr[OFF-1:0] == '0); // R6
  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    wb_done |=> !wb_busy); // R8
  AST_OE_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    addr_oe |-> wb_busy); // R9
  AST_BUSY_HOLDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_busy && $past(wb_busy) |-> $stable(wb_addr[ADDR_W-1:OFF])); // R11

endmodule

// File: tb/snoop_wb_sched_bench.sv
module snoop_wb_sched_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DLY        = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        hitm_req, flush_now, cyc_issue, cyc_retire, beat_rdy, addr_hold, ctl_float;
  logic [31:0] snoop_addr;
  logic        wb_start, wb_busy, addr_oe, wb_done;
  logic [31:0] wb_addr;

  int n_checks = 0;
  int n_fail   = 0;

  // behavioural reference state
  int          m_phase;   // 0 idle, 1 waiting drain, 2 counting delay, 3 burst
  int          m_cnt, m_out, m_beat;
  logic [31:0] m_base;
  bit          m_flush;
  bit          seen_start;

  always #(CLK_PERIOD/2) clk = ~clk;

  snoop_wb_sched u_snoop_wb_sched (
    .clk(clk), .rst_n(rst_n), .hitm_req(hitm_req), .snoop_addr(snoop_addr),
    .flush_now(flush_now), .cyc_issue(cyc_issue), .cyc_retire(cyc_retire),
    .beat_rdy(beat_rdy), .addr_hold(addr_hold), .ctl_float(ctl_float),
    .wb_start(wb_start), .wb_busy(wb_busy), .wb_addr(wb_addr),
    .addr_oe(addr_oe), .wb_done(wb_done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // compare every clock, then advance the model across the edge
  task automatic tick();
    bit e_start, e_busy, e_oe, e_done, q;
    int nxt;
    #1;
    e_start = (m_phase == 2) && (m_cnt == DLY) && !ctl_float;
    e_busy  = (m_phase != 0);
    e_oe    = (e_start || m_phase == 3) && !addr_hold;
    e_done  = (m_phase == 3) && beat_rdy && (m_beat == 3);
    chk(wb_start == e_start, "R2 wb_start", wb_start, e_start);
    chk(wb_busy  == e_busy,  "R1 wb_busy",  wb_busy,  e_busy);
    chk(addr_oe  == e_oe,    "R9 addr_oe",  addr_oe,  e_oe);
    chk(wb_done  == e_done,  "R8 wb_done",  wb_done,  e_done);
    if (e_busy)
      chk(wb_addr == m_base + 32'(m_beat * 8), "R6 wb_addr", wb_addr, m_base + 32'(m_beat * 8));
    seen_start = wb_start;
    @(posedge clk);
    q = (m_out == 0) || (m_out == 1 && cyc_retire && !cyc_issue) ||
        ((m_phase == 0) ? flush_now : m_flush);
    nxt = m_out + int'(cyc_issue) - int'(cyc_retire);
    if (nxt > 3) nxt = 3;
    if (nxt < 0) nxt = 0;
    if (cyc_issue && cyc_retire) nxt = m_out;
    m_out = nxt;
    case (m_phase)
      0: if (hitm_req) begin
           m_base  = {snoop_addr[31:5], 5'b0};
           m_flush = flush_now;
           if (q) begin m_phase = 2; m_cnt = 1; end else m_phase = 1;
         end
      1: if (q) begin m_phase = 2; m_cnt = 1; end
      2: begin
           if (m_cnt == DLY && !ctl_float) begin m_phase = 3; m_beat = 0; end
           else if (m_cnt < DLY) m_cnt++;
         end
      default: if (beat_rdy) begin
           if (m_beat == 3) begin m_phase = 0; m_beat = 0; end else m_beat++;
         end
    endcase
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    hitm_req = 0; flush_now = 0; cyc_issue = 0; cyc_retire = 0;
    beat_rdy = 0; addr_hold = 0; ctl_float = 0; snoop_addr = '0;
  endtask

  // counts clocks after the reference clock until the strobe is seen
  task automatic count_to_start(input string req, input int exp);
    int n = 0;
    seen_start = 0;
    while (!seen_start && n < 20) begin tick(); n++; end
    chk(n == exp, req, n, exp);
  endtask

  task automatic run_burst(input int gap);
    for (int b = 0; b < 4; b++) begin
      repeat (gap) tick();
      beat_rdy = 1; tick(); beat_rdy = 0;
    end
    tick();
    chk(wb_busy == 0, "R8 busy after last beat", wb_busy, 0);
  endtask

  initial begin
    m_phase = 0; m_cnt = 0; m_out = 0; m_beat = 0; m_base = '0; m_flush = 0;
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(!wb_start && !wb_busy && !addr_oe && !wb_done, "R1 reset outputs",
        {wb_start, wb_busy, addr_oe, wb_done}, 0);
    rst_n = 1;
    repeat (2) tick();

    // R2/R6/R7/R8: idle bus, low address bits set, gapped beats
    hitm_req = 1; snoop_addr = 32'h1234_567F; tick(); hitm_req = 0; snoop_addr = '0;
    count_to_start("R2 start latency idle bus", DLY);
    chk(wb_addr == 32'h1234_5660, "R6 beat0 address", wb_addr, 32'h1234_5660);
    repeat (3) tick();
    chk(wb_addr == 32'h1234_5660, "R7 no advance without ready", wb_addr, 32'h1234_5660);
    run_burst(1);

    // R3: two cycles in flight
    cyc_issue = 1; tick(); tick(); cyc_issue = 0;
    hitm_req = 1; snoop_addr = 32'h0000_8040; tick(); hitm_req = 0;
    repeat (3) tick();
    chk(wb_busy && !seen_start, "R3 waiting while in flight", seen_start, 0);
    cyc_retire = 1; tick(); cyc_retire = 0;
    repeat (2) tick();
    cyc_retire = 1; tick(); cyc_retire = 0;
    count_to_start("R3 start after last retire", DLY);
    run_burst(0);

    // R5: saturation at three
    cyc_issue = 1; repeat (4) tick(); cyc_issue = 0;
    hitm_req = 1; snoop_addr = 32'hABCD_EF00; tick(); hitm_req = 0;
    cyc_retire = 1; tick(); tick(); cyc_retire = 0; tick();
    chk(!seen_start, "R5 no start with one left", seen_start, 0);
    cyc_retire = 1; tick(); cyc_retire = 0;
    count_to_start("R5 start after third retire", DLY);
    run_burst(0);

    // R4: flush overrides in-flight cycle
    cyc_issue = 1; tick(); cyc_issue = 0;
    hitm_req = 1; flush_now = 1; snoop_addr = 32'h0F0F_0F20; tick();
    hitm_req = 0; flush_now = 0;
    count_to_start("R4 flush start latency", DLY);
    run_burst(0);
    cyc_retire = 1; tick(); cyc_retire = 0;

    // R9: address hold over the strobe, released mid-burst
    addr_hold = 1;
    hitm_req = 1; snoop_addr = 32'h7777_7700; tick(); hitm_req = 0;
    count_to_start("R9 start under address hold", DLY);
    chk(addr_oe == 0, "R9 oe low under hold", addr_oe, 0);
    beat_rdy = 1; tick(); beat_rdy = 0;
    addr_hold = 0; #1;
    chk(addr_oe == 1, "R9 oe after hold release", addr_oe, 1);
    run_burst(0);

    // R10: float across the delay
    hitm_req = 1; snoop_addr = 32'h2222_0000; tick(); hitm_req = 0;
    ctl_float = 1;
    repeat (4) tick();
    chk(!seen_start && wb_busy, "R10 blocked while floated", seen_start, 0);
    ctl_float = 0;
    count_to_start("R10 start after float release", 0 + 1);
    run_burst(0);

    // R11: request while busy is ignored
    hitm_req = 1; snoop_addr = 32'h3000_0000; tick(); hitm_req = 0;
    count_to_start("R11 first start", DLY);
    hitm_req = 1; snoop_addr = 32'h4444_4440; tick(); hitm_req = 0;
    chk(wb_addr[31:5] == 27'(32'h3000_0000 >> 5), "R11 line kept", wb_addr, 32'h3000_0008);
    run_burst(0);
    seen_start = 0;
    for (int i = 0; i < 6; i++) begin
      tick();
      chk(!seen_start && !wb_busy, "R11 no second start", seen_start, 0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule